// File: doc/BRIEF.md
# Address-Masked GPIO Register Port

An eight-pin general-purpose I/O port reached through a byte-wide register interface on a simple APB-style bus. Each pin can be an input or an output. The data register sits behind a window of word offsets, and the word address acts as a per-pin mask. A write changes only the pins named by the mask, and a read shows only those pins. Software can therefore set or clear one pin in a single bus access, with no read-modify-write sequence.

The port also holds the interrupt configuration registers: trigger sense, both-edge select, event polarity and enable. It presents their values to a separate edge/level detection unit, together with the synchronised pin levels. It reads back that unit's raw status and forms the masked status from it. A write to the clear register produces a one-cycle clear strobe toward the detection unit. Inputs pass through a two-flop synchroniser before they are sampled.

Top module: `gpio_mask_port`

## Requirements
- R1: After a synchronous active-low reset, direction, output latch, the four interrupt configuration registers and the clear strobe are all 0, so every pin is an input with its enable low.
- R2: A write to byte offsets 0x000–0x3FC updates the output latch only in bit positions where address bits [9:2] are 1. All other latch bits keep their value.
- R3: A read from offsets 0x000–0x3FC returns 0 in every bit whose mask bit (address bits [9:2]) is 0. In a masked bit it returns the output latch for output pins and the synchronised input for input pins.
- R4: A read at offset 1<<(n+2) returns a nonzero value exactly when pin n reads high.
- R5: The direction register at offset 0x400 is readable and writable. A 1 in bit n drives pin n's output enable high, and the pin outputs carry the output latch.
- R6: The sense (0x404), both-edge (0x408), event (0x40C) and enable (0x410) registers read back what was written and appear unchanged on their configuration outputs.
- R7: Offset 0x414 reads the detection unit's raw status. Offset 0x418 reads raw status AND enable. Writes to either offset change no register.
- R8: A write to offset 0x41C raises the clear strobe to the written byte for exactly the one cycle after the write. A read of 0x41C returns 0.
- R9: A change on an input pin appears on the synchronised pin outputs after the second rising clock edge, and not after the first.
- R10: Reads from offsets outside the window and the eight control words (for example 0x420 or 0x800) return 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 10 | Byte address bits [11:2] (word address) |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data, valid while a read is selected |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| pin_oe | output | 8 | Pad output enables |
| pin_out | output | 8 | Pad output values |
| pin_sync | output | 8 | Synchronised input levels for the detection unit |
| irq_sense | output | 8 | Per-pin level (1) or edge (0) sensing |
| irq_both | output | 8 | Per-pin both-edge select |
| irq_event | output | 8 | Per-pin polarity: high/rising when 1 |
| irq_enable | output | 8 | Per-pin interrupt enable |
| irq_raw | input | 8 | Raw status from the detection unit |
| irq_clear | output | 8 | One-cycle clear strobe to the detection unit |

## Verification
The bench goes after the mask window with full, partial and empty masks. A design that ignored the mask would alter untouched pins or leak their levels into reads. A design that used the wrong source per pin would return the latch for an input, or the pad level for an output. It walks every single-pin offset, because an off-by-one in the mask slice would move each pin's access to its neighbour's. It checks that the synchroniser is exactly two stages deep, that the clear strobe lasts one cycle, and that writes to read-only and unmapped offsets leave every register intact.

// File: rtl/gpio_pkg.sv
// Shared constants, register indices and the address decoder of the GPIO port.
// Assumes the word address (byte address bits [ADDR_W-1:2]) is presented.
package gpio_pkg;
    localparam int PIN_W  = 8;                 // pins per port
    localparam int ADDR_W = 12;                // byte address width
    localparam int WA_W   = ADDR_W - 2;        // word address width
    localparam int BLK_W  = WA_W - PIN_W;      // block-select field width

    typedef enum logic [2:0] {
        IDX_DIR    = 3'd0,
        IDX_SENSE  = 3'd1,
        IDX_BOTH   = 3'd2,
        IDX_EVENT  = 3'd3,
        IDX_ENABLE = 3'd4,
        IDX_RAW    = 3'd5,
        IDX_MASKED = 3'd6,
        IDX_CLEAR  = 3'd7
    } ctl_idx_e;

    typedef struct packed {
        logic             win;   // data window hit
        logic             ctl;   // control word hit
        ctl_idx_e         idx;   // control word index
        logic [PIN_W-1:0] mask;  // per-pin mask from the address
    } addr_dec_t;

    // Split a word address into window/control hits, index and pin mask.
    function automatic addr_dec_t decode_addr(input logic [WA_W-1:0] wa);
        addr_dec_t d;
        d.win  = (wa[WA_W-1:PIN_W] == '0);
        d.ctl  = (wa[WA_W-1:PIN_W] == BLK_W'(1)) && (wa[PIN_W-1:3] == '0);
        d.idx  = ctl_idx_e'(wa[2:0]);
        d.mask = wa[PIN_W-1:0];
        return d;
    endfunction
endpackage

// File: rtl/gpio_sync.sv
// Two-flop synchroniser, one chain per pin.
// Assumes pin inputs are asynchronous to clk; reset clears both stages.
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    for (genvar g = 0; g < W; g++) begin : g_pin
        logic s1_q, s2_q;
        // Two back-to-back capture stages for pin g.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1_q <= 1'b0;
                s2_q <= 1'b0;
            end else begin
                s1_q <= async_in[g];
                s2_q <= s1_q;
            end
        end
        assign sync_out[g] = s2_q;
    end

    // R9: output equals the input seen two edges earlier.
    p_two_stage_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (sync_out == $past(async_in, 2)));
endmodule

// File: rtl/gpio_regfile.sv
// Writable state of the port: output latch, direction, interrupt
// configuration and the one-cycle clear strobe.
// Assumes wr_en is a single-cycle commit strobe from the bus.
module gpio_regfile
    import gpio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WA_W-1:0]  waddr,
    input  logic [PIN_W-1:0] wdata,
    output logic [PIN_W-1:0] out_q,
    output logic [PIN_W-1:0] dir_q,
    output logic [PIN_W-1:0] sense_q,
    output logic [PIN_W-1:0] both_q,
    output logic [PIN_W-1:0] event_q,
    output logic [PIN_W-1:0] en_q,
    output logic [PIN_W-1:0] clr_q
);
    addr_dec_t dec;
    assign dec = decode_addr(waddr);

    logic wr_win, wr_ctl;
    assign wr_win = wr_en && dec.win;
    assign wr_ctl = wr_en && dec.ctl;

    // Output latch: masked update through the data window.
    always_ff @(posedge clk) begin
        if (!rst_n)      out_q <= '0;
        else if (wr_win) out_q <= (out_q & ~dec.mask) | (wdata & dec.mask);
    end

    // Direction and interrupt configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= '0;
            sense_q <= '0;
            both_q  <= '0;
            event_q <= '0;
            en_q    <= '0;
        end else if (wr_ctl) begin
            case (dec.idx)
                IDX_DIR:    dir_q   <= wdata;
                IDX_SENSE:  sense_q <= wdata;
                IDX_BOTH:   both_q  <= wdata;
                IDX_EVENT:  event_q <= wdata;
                IDX_ENABLE: en_q    <= wdata;
                default:    ;
            endcase
        end
    end

    // Clear strobe: holds the written byte for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                            clr_q <= '0;
        else if (wr_ctl && dec.idx == IDX_CLEAR) clr_q <= wdata;
        else                                   clr_q <= '0;
    end

    // R2: unmasked latch bits never change on a window write.
    p_window_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_win |=> ((out_q ^ $past(out_q)) & ~$past(dec.mask)) == '0);
    // R2: masked latch bits take the written data.
    p_window_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_win |=> (out_q & $past(dec.mask)) == ($past(wdata) & $past(dec.mask)));
    // R5: a direction write lands in the direction register.
    p_dir_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && dec.idx == IDX_DIR) |=> dir_q == $past(wdata));
    // R7: writes to status offsets leave configuration untouched.
    p_status_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && (dec.idx == IDX_RAW || dec.idx == IDX_MASKED)) |=>
        ($stable(dir_q) && $stable(sense_q) && $stable(both_q) &&
         $stable(event_q) && $stable(en_q) && $stable(out_q)));
    // R8: the strobe is only ever the cycle after a clear write.
    p_clr_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_q != '0) |-> $past(wr_ctl && dec.idx == IDX_CLEAR));
    // R10: unmapped writes change nothing.
    p_unmapped_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !dec.win && !dec.ctl) |=>
        ($stable(dir_q) && $stable(en_q) && $stable(out_q) && $stable(sense_q)));
endmodule

// File: rtl/gpio_rdmux.sv
// Read-data selection for the data window and the control words.
// Assumes rd_en is high for the whole selected read; output is combinational.
module gpio_rdmux
    import gpio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [WA_W-1:0]  raddr,
    input  logic [PIN_W-1:0] out_q,
    input  logic [PIN_W-1:0] dir_q,
    input  logic [PIN_W-1:0] sense_q,
    input  logic [PIN_W-1:0] both_q,
    input  logic [PIN_W-1:0] event_q,
    input  logic [PIN_W-1:0] en_q,
    input  logic [PIN_W-1:0] pin_lvl,
    input  logic [PIN_W-1:0] raw_st,
    output logic [PIN_W-1:0] rdata
);
    addr_dec_t dec;
    assign dec = decode_addr(raddr);

    logic [PIN_W-1:0] level;
    // Per pin: driven value for outputs, synchronised level for inputs.
    assign level = (dir_q & out_q) | (~dir_q & pin_lvl);

    // Select the addressed source, zero for anything unmapped.
    always_comb begin
        rdata = '0;
        if (rd_en && dec.win) begin
            rdata = level & dec.mask;
        end else if (rd_en && dec.ctl) begin
            case (dec.idx)
                IDX_DIR:    rdata = dir_q;
                IDX_SENSE:  rdata = sense_q;
                IDX_BOTH:   rdata = both_q;
                IDX_EVENT:  rdata = event_q;
                IDX_ENABLE: rdata = en_q;
                IDX_RAW:    rdata = raw_st;
                IDX_MASKED: rdata = raw_st & en_q;
                default:    rdata = '0;
            endcase
        end
    end

    // R3: unmasked bits of a window read are zero.
    p_masked_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && dec.win) |-> (rdata & ~dec.mask) == '0);
    // R10: unmapped reads return zero.
    p_unmapped_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !dec.win && !dec.ctl) |-> rdata == '0);
    // R7: masked status never shows a disabled pin.
    p_masked_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && dec.ctl && dec.idx == IDX_MASKED) |-> (rdata & ~en_q) == '0);
endmodule

// File: rtl/gpio_mask_port.sv
// Eight-pin GPIO port with an address-masked data window and interrupt
// configuration registers for an external detection unit.
// Assumes a zero-wait APB-style bus: writes commit in the access phase.
module gpio_mask_port
    import gpio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             psel,
    input  logic             penable,
    input  logic             pwrite,
    input  logic [WA_W-1:0]  paddr,
    input  logic [PIN_W-1:0] pwdata,
    output logic [PIN_W-1:0] prdata,
    input  logic [PIN_W-1:0] pin_in,
    output logic [PIN_W-1:0] pin_oe,
    output logic [PIN_W-1:0] pin_out,
    output logic [PIN_W-1:0] pin_sync,
    output logic [PIN_W-1:0] irq_sense,
    output logic [PIN_W-1:0] irq_both,
    output logic [PIN_W-1:0] irq_event,
    output logic [PIN_W-1:0] irq_enable,
    input  logic [PIN_W-1:0] irq_raw,
    output logic [PIN_W-1:0] irq_clear
);
    logic wr_en, rd_en;
    // Bus strobes: write commits in access phase; read data while selected.
    assign wr_en = psel && penable && pwrite;
    assign rd_en = psel && !pwrite;

    logic [PIN_W-1:0] out_q, dir_q;

    gpio_sync #(.W(PIN_W)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_regfile i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .waddr   (paddr),
        .wdata   (pwdata),
        .out_q   (out_q),
        .dir_q   (dir_q),
        .sense_q (irq_sense),
        .both_q  (irq_both),
        .event_q (irq_event),
        .en_q    (irq_enable),
        .clr_q   (irq_clear)
    );

    gpio_rdmux i_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .raddr   (paddr),
        .out_q   (out_q),
        .dir_q   (dir_q),
        .sense_q (irq_sense),
        .both_q  (irq_both),
        .event_q (irq_event),
        .en_q    (irq_enable),
        .pin_lvl (pin_sync),
        .raw_st  (irq_raw),
        .rdata   (prdata)
    );

    // Pad drive straight from the registers.
    assign pin_oe  = dir_q;
    assign pin_out = out_q;

    // R1: the cycle after reset every pin is an input and nothing is enabled.
    p_reset_state_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (pin_oe == '0 && pin_out == '0 && irq_enable == '0 && irq_clear == '0));
endmodule

// File: tb/test_gpio_mask_port.sv
module test_gpio_mask_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [9:0] paddr = '0;
    logic [7:0] pwdata = '0;
    logic [7:0] prdata;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_oe, pin_out, pin_sync;
    logic [7:0] irq_sense, irq_both, irq_event, irq_enable, irq_clear;
    logic [7:0] irq_raw = '0;

    int checks = 0;
    int bad = 0;
    bit done = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;   // 250 MHz

    gpio_mask_port i_gpio_mask_port (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .pin_sync(pin_sync),
        .irq_sense(irq_sense), .irq_both(irq_both), .irq_event(irq_event),
        .irq_enable(irq_enable), .irq_raw(irq_raw), .irq_clear(irq_clear)
    );

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    // Monitor: compare each read access phase against the scoreboard.
    always @(negedge clk) begin
        if (psel && penable && !pwrite) begin
            if (exp_q.size() == 0) begin
                checks++; bad++;
                $display("FAIL scoreboard: got %02h expected none", prdata);
            end else begin
                check(prdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        psel = 1; pwrite = 1; penable = 0; paddr = a[11:2]; pwdata = d;
        @(posedge clk); #1;
        penable = 1;
        @(posedge clk); #1;
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic bus_read(input logic [11:0] a, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(posedge clk); #1;
        psel = 1; pwrite = 0; penable = 0; paddr = a[11:2];
        @(posedge clk); #1;
        penable = 1;
        @(posedge clk); #1;
        psel = 0; penable = 0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] lvl;
        repeat (4) @(posedge clk);
        #1 rst_n = 1;

        // R1: reset state
        check(pin_oe, 8'h00, "R1 oe");
        check(pin_out, 8'h00, "R1 out");
        check(irq_enable | irq_sense | irq_both | irq_event, 8'h00, "R1 cfg");
        check(irq_clear, 8'h00, "R1 clear");
        bus_read(12'h400, 8'h00, "R1 dir read");

        // R5: direction
        bus_write(12'h400, 8'hF0);
        check(pin_oe, 8'hF0, "R5 oe");
        bus_read(12'h400, 8'hF0, "R5 dir read");

        // R2: full, partial and empty masks
        bus_write(12'h3FC, 8'hA5);
        check(pin_out, 8'hA5, "R2 full mask");
        bus_write(12'h03C, 8'h00);
        check(pin_out, 8'hA0, "R2 low nibble mask");
        bus_write(12'h000, 8'hFF);
        check(pin_out, 8'hA0, "R2 empty mask");
        bus_write(12'h300, 8'h40);
        check(pin_out, 8'h60, "R2 two-bit mask");

        // R3: mixed direction read
        pin_in = 8'h3C;
        repeat (3) @(posedge clk);
        #1;
        lvl = (8'h60 & 8'hF0) | (8'h3C & 8'h0F);   // 6C
        bus_read(12'h3FC, lvl, "R3 full read");
        bus_read(12'h0C0, lvl & 8'h30, "R3 partial read");
        bus_read(12'h000, 8'h00, "R3 empty mask read");

        // R4: single-pin offsets
        for (int n = 0; n < 8; n++) begin
            bus_read(12'(1 << (n + 2)), lvl & 8'(1 << n), "R4 single pin");
        end

        // R6: configuration registers
        bus_write(12'h404, 8'h11);
        bus_write(12'h408, 8'h22);
        bus_write(12'h40C, 8'h33);
        bus_write(12'h410, 8'h0F);
        check(irq_sense, 8'h11, "R6 sense out");
        check(irq_both, 8'h22, "R6 both out");
        check(irq_event, 8'h33, "R6 event out");
        check(irq_enable, 8'h0F, "R6 enable out");
        bus_read(12'h404, 8'h11, "R6 sense read");
        bus_read(12'h408, 8'h22, "R6 both read");
        bus_read(12'h40C, 8'h33, "R6 event read");
        bus_read(12'h410, 8'h0F, "R6 enable read");

        // R7: status registers
        irq_raw = 8'hF3;
        bus_read(12'h414, 8'hF3, "R7 raw");
        bus_read(12'h418, 8'h03, "R7 masked");
        bus_write(12'h414, 8'hFF);
        bus_write(12'h418, 8'hFF);
        bus_read(12'h410, 8'h0F, "R7 enable kept");
        bus_read(12'h400, 8'hF0, "R7 dir kept");
        bus_read(12'h414, 8'hF3, "R7 raw after write");

        // R8: clear strobe
        bus_write(12'h41C, 8'h5A);
        check(irq_clear, 8'h5A, "R8 strobe");
        @(posedge clk); #1;
        check(irq_clear, 8'h00, "R8 strobe ends");
        bus_read(12'h41C, 8'h00, "R8 clear reads zero");

        // R9: two-stage synchroniser
        @(posedge clk); #1;
        pin_in = 8'h81;
        @(posedge clk); #1;
        check(pin_sync, 8'h3C, "R9 one edge");
        @(posedge clk); #1;
        check(pin_sync, 8'h81, "R9 two edges");
        bus_read(12'h03C, 8'h01, "R9 input read");

        // R10: unmapped offsets
        bus_write(12'h420, 8'hFF);
        bus_write(12'h800, 8'hFF);
        bus_write(12'hC00, 8'h00);
        bus_read(12'h400, 8'hF0, "R10 dir kept");
        bus_read(12'h410, 8'h0F, "R10 enable kept");
        check(pin_out, 8'h60, "R10 latch kept");
        bus_read(12'h420, 8'h00, "R10 read 420");
        bus_read(12'h800, 8'h00, "R10 read 800");

        repeat (2) @(posedge clk);
        if (exp_q.size() != 0) begin
            checks++; bad++;
            $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule